// File: doc/BRIEF.md
# Spectral Channel Aggregator

This block lowers the spectral resolution of correlation output after integration. For each correlation product it receives one complex accumulator per frequency bin, with bins arriving in ascending order from index 0. It adds together runs of adjacent bins and emits one complex sum per run. This cuts the output volume by the same factor as the loss in resolution.

The run length is set at run time as a power of two, written as its base-2 logarithm. Setting 0 gives length 1, which passes every bin through unchanged. The largest setting is 6, a run of 64 bins. Both streams use a valid/ready handshake. The output carries the coarse bin index and real and imaginary sums that are six bits wider than the input, so no input pattern can overflow them.

A new run length never splits a product. A write is held as pending and becomes active only when the next bin with index 0 is accepted.

Top module: `chan_agg`

## Requirements
- R1: After reset `m_valid` is 0, `s_ready` is 1 and the run length is 1 (bypass).
- R2: With run length 1, every accepted input bin produces one output with the same bin index and the sign-extended real and imaginary values.
- R3: With setting k from 1 to 6, bins are summed in consecutive groups of 2^k aligned to multiples of 2^k. One output is produced per group, and it becomes valid on the cycle after the group's last bin (low k index bits all ones) is accepted. Its index is the input index shifted right by k.
- R4: The real and imaginary parts are summed independently as signed values in DATA_W+6 bits, so 64 bins at the most negative or most positive input give the exact sum.
- R5: A write on the configuration port (`cfg_valid` high, `cfg_log2` from 0 to 6) selects a run length of 2^cfg_log2 starting with the next accepted bin of index 0.
- R6: A write that arrives while a product is partway through has no effect on the rest of that product, which finishes with the previous run length.
- R7: A write with `cfg_log2` above 6 is ignored, and the previous setting stays pending.
- R8: While `m_valid` is 1 and `m_ready` is 0, `s_ready` is 0 and the output index and data hold steady. No output is lost or duplicated.
- R9: Cycles with `s_valid` low leave the partial group sum unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_log2 | input | LOG_W (3) | Base-2 log of the run length (0..6) |
| s_valid | input | 1 | Input bin valid |
| s_ready | output | 1 | Input bin accepted when high with s_valid |
| s_bin | input | BIN_W (10) | Input frequency bin index |
| s_re | input | DATA_W | Signed real accumulator |
| s_im | input | DATA_W | Signed imaginary accumulator |
| m_valid | output | 1 | Output sum valid |
| m_ready | input | 1 | Downstream accepts output |
| m_bin | output | BIN_W (10) | Coarse bin index |
| m_re | output | DATA_W+6 | Signed real sum |
| m_im | output | DATA_W+6 | Signed imaginary sum |

## Verification
The assertions check three things on every cycle. While a pending output is refused, input is blocked and the output holds. The active run length moves only when a bin of index 0 is accepted. The partial sums and the pending setting do not change unless an accepted bin or a legal write causes it. The arithmetic itself can only be shown by the bench's scenarios: that the group sums are correct, that the coarse index is right, that a mid-product change is deferred, that an illegal setting is rejected, and that extreme values do not overflow. These scenarios compare complete products against sums computed independently, under idle gaps and random backpressure.

// File: rtl/chan_agg_pkg.sv
package chan_agg_pkg;
   // largest run length exponent (run of 64 bins)
   localparam int AGG_MAX_LOG = 6;
   // lane numbering inside the datapath
   localparam int LANE_RE = 0;
   localparam int LANE_IM = 1;
   localparam int N_LANES = 2;
endpackage

// File: rtl/chan_agg_cfg.sv
module chan_agg_cfg #(
   parameter int MAX_LOG = 6,
   parameter int BIN_W = 10,
   parameter int LOG_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_valid,
   input  logic [LOG_W-1:0] cfg_log2,
   input  logic             in_fire,
   input  logic [BIN_W-1:0] in_bin,
   output logic [LOG_W-1:0] eff_log
);
   logic [LOG_W-1:0] pend_log;
   logic [LOG_W-1:0] act_log;
   logic             blk_start;
   logic             cfg_ok;

   assign blk_start = (in_bin == '0);
   assign cfg_ok    = cfg_valid && (int'(cfg_log2) <= MAX_LOG);
   // a new block picks up the pending setting on its very first bin
   assign eff_log   = blk_start ? pend_log : act_log;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_log <= '0;
         act_log  <= '0;
      end else begin
         if (cfg_ok)
            pend_log <= cfg_log2;
         if (in_fire && blk_start)
            act_log <= pend_log;
      end
   end

   assert_act_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_fire && blk_start) |=> $stable(act_log));

   assert_bad_cfg_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && int'(cfg_log2) > MAX_LOG) |=> $stable(pend_log));

   always_comb begin
      if (rst_n) assert_range_R5: assert (int'(pend_log) <= MAX_LOG);
   end
endmodule

// File: rtl/chan_agg_lane.sv
module chan_agg_lane #(
   parameter int IN_W  = 32,
   parameter int OUT_W = 38
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_fire,
   input  logic                    grp_first,
   input  logic signed [IN_W-1:0]  din,
   output logic signed [OUT_W-1:0] sum
);
   logic signed [OUT_W-1:0] acc;
   logic signed [OUT_W-1:0] base;

   assign base = grp_first ? '0 : acc;
   assign sum  = base + OUT_W'(din);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc <= '0;
      else if (in_fire)
         acc <= sum;
   end

   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_fire |=> $stable(acc));
endmodule

// File: rtl/chan_agg.sv
module chan_agg
   import chan_agg_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int NBINS   = 1024,
   parameter int MAX_LOG = AGG_MAX_LOG,
   localparam int BIN_W  = $clog2(NBINS),
   localparam int OUT_W  = DATA_W + MAX_LOG,
   localparam int LOG_W  = $clog2(MAX_LOG + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_valid,
   input  logic [LOG_W-1:0]        cfg_log2,
   input  logic                    s_valid,
   output logic                    s_ready,
   input  logic [BIN_W-1:0]        s_bin,
   input  logic signed [DATA_W-1:0] s_re,
   input  logic signed [DATA_W-1:0] s_im,
   output logic                    m_valid,
   input  logic                    m_ready,
   output logic [BIN_W-1:0]        m_bin,
   output logic signed [OUT_W-1:0] m_re,
   output logic signed [OUT_W-1:0] m_im
);
   if (BIN_W < MAX_LOG) begin : g_bad_bins
      $error("chan_agg: NBINS must cover the largest run length");
   end
   if ((1 << BIN_W) != NBINS) begin : g_bad_pow2
      $error("chan_agg: NBINS must be a power of two");
   end

   logic             in_fire;
   logic [LOG_W-1:0] eff_log;
   logic [BIN_W-1:0] grp_mask;
   logic             grp_first;
   logic             grp_last;
   logic signed [DATA_W-1:0] lane_in  [N_LANES];
   logic signed [OUT_W-1:0]  lane_sum [N_LANES];

   assign s_ready = !m_valid || m_ready;
   assign in_fire = s_valid && s_ready;

   chan_agg_cfg #(.MAX_LOG(MAX_LOG), .BIN_W(BIN_W), .LOG_W(LOG_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_log2(cfg_log2),
      .in_fire(in_fire), .in_bin(s_bin), .eff_log(eff_log));

   always_comb begin
      grp_mask = '0;
      for (int i = 0; i < MAX_LOG; i++)
         if (i < int'(eff_log)) grp_mask[i] = 1'b1;
   end

   assign grp_first = ((s_bin & grp_mask) == '0);
   assign grp_last  = ((s_bin & grp_mask) == grp_mask);

   assign lane_in[LANE_RE] = s_re;
   assign lane_in[LANE_IM] = s_im;

   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      chan_agg_lane #(.IN_W(DATA_W), .OUT_W(OUT_W)) u_lane (
         .clk(clk), .rst_n(rst_n), .in_fire(in_fire), .grp_first(grp_first),
         .din(lane_in[g]), .sum(lane_sum[g]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_valid <= 1'b0;
         m_bin   <= '0;
         m_re    <= '0;
         m_im    <= '0;
      end else begin
         if (m_valid && m_ready)
            m_valid <= 1'b0;
         if (in_fire && grp_last) begin
            m_valid <= 1'b1;
            m_bin   <= s_bin >> eff_log;
            m_re    <= lane_sum[LANE_RE];
            m_im    <= lane_sum[LANE_IM];
         end
      end
   end

   assert_stall_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |-> !s_ready);

   assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_bin) && $stable(m_re) && $stable(m_im)));
endmodule

// File: tb/chan_agg_tb.sv
module chan_agg_tb;
   localparam int DW = 16;
   localparam int NB = 256;
   localparam int BW = $clog2(NB);
   localparam int OW = DW + 6;

   logic clk = 0, rst_n = 0;
   logic cfg_valid = 0;
   logic [2:0] cfg_log2 = 0;
   logic s_valid = 0, s_ready;
   logic [BW-1:0] s_bin = 0;
   logic signed [DW-1:0] s_re = 0, s_im = 0;
   logic m_valid, m_ready = 1;
   logic [BW-1:0] m_bin;
   logic signed [OW-1:0] m_re, m_im;

   int total = 0, bad = 0;
   bit gap_en = 0, bp_en = 0;
   int q_bin[$];
   longint q_re[$], q_im[$];
   int st_chk = 0, st_bad = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #4 clk = ~clk;

   chan_agg #(.DATA_W(DW), .NBINS(NB)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_log2(cfg_log2),
      .s_valid(s_valid), .s_ready(s_ready), .s_bin(s_bin), .s_re(s_re), .s_im(s_im),
      .m_valid(m_valid), .m_ready(m_ready), .m_bin(m_bin), .m_re(m_re), .m_im(m_im));

   // downstream ready pattern
   always @(posedge clk) begin
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      m_ready = bp_en ? lfsr[0] : 1'b1;
   end

   // output monitor and stall stability check (R8)
   logic pv = 0, pr = 0;
   int pb;
   longint pre_v, pim_v;
   always @(negedge clk) begin
      if (rst_n) begin
         if (pv && !pr) begin
            st_chk++;
            if (!(m_valid && int'(m_bin) == pb && longint'(m_re) == pre_v && longint'(m_im) == pim_v))
               st_bad++;
         end
         if (m_valid && m_ready) begin
            q_bin.push_back(int'(m_bin));
            q_re.push_back(longint'(m_re));
            q_im.push_back(longint'(m_im));
         end
         pv = m_valid; pr = m_ready; pb = int'(m_bin);
         pre_v = longint'(m_re); pim_v = longint'(m_im);
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic longint vre(int b, int seed, int mode);
      if (mode == 1) return -(longint'(1) << (DW-1));
      if (mode == 2) return (longint'(1) << (DW-1)) - 1;
      return longint'(((b * 37 + seed * 101) % 2001) - 1000);
   endfunction

   function automatic longint vim(int b, int seed, int mode);
      if (mode == 1) return (longint'(1) << (DW-1)) - 1;
      if (mode == 2) return -(longint'(1) << (DW-1));
      return longint'(((b * 53 + seed * 7) % 1501) - 700);
   endfunction

   task automatic set_cfg(input int v);
      @(posedge clk); #1;
      cfg_valid = 1; cfg_log2 = 3'(v);
      @(posedge clk); #1;
      cfg_valid = 0;
   endtask

   task automatic send_bin(input int b, input int seed, input int mode, input int mid_cfg);
      if (gap_en) begin
         s_valid = 0;
         repeat (b % 3) @(posedge clk);
         #1;
      end
      s_valid = 1; s_bin = BW'(b);
      s_re = DW'(vre(b, seed, mode)); s_im = DW'(vim(b, seed, mode));
      if (mid_cfg >= 0 && b == NB / 2) begin cfg_valid = 1; cfg_log2 = 3'(mid_cfg); end
      do @(negedge clk); while (!s_ready);
      @(posedge clk); #1;
      s_valid = 0; cfg_valid = 0;
   endtask

   task automatic run_block(input int k, input int seed, input int mode,
                            input int mid_cfg, input string req);
      int n, errs;
      q_bin.delete(); q_re.delete(); q_im.delete();
      for (int b = 0; b < NB; b++) send_bin(b, seed, mode, mid_cfg);
      repeat (30) @(posedge clk);
      #1;
      n = NB >> k;
      check(q_bin.size() == n, req, "output count", q_bin.size(), n);
      errs = 0;
      for (int g = 0; g < n && g < q_bin.size(); g++) begin
         longint er = 0, ei = 0;
         for (int j = 0; j < (1 << k); j++) begin
            er += vre(g * (1 << k) + j, seed, mode);
            ei += vim(g * (1 << k) + j, seed, mode);
         end
         if (q_bin[g] != g || q_re[g] != er || q_im[g] != ei) begin
            errs++;
            if (errs < 4)
               $display("FAIL %s group %0d: actual bin=%0d re=%0d im=%0d expected bin=%0d re=%0d im=%0d",
                        req, g, q_bin[g], q_re[g], q_im[g], g, er, ei);
         end
      end
      total++;
      if (errs != 0) bad++;
   endtask

   task automatic t_reset();
      #1;
      check(m_valid == 0, "R1", "m_valid in reset", m_valid, 0);
      check(s_ready == 1, "R1", "s_ready in reset", s_ready, 1);
   endtask

   task automatic t_latency();  // R3 output appears the cycle after the last bin
      set_cfg(2);
      for (int b = 0; b < 3; b++) begin
         s_valid = 1; s_bin = BW'(b); s_re = 1; s_im = 2;
         @(posedge clk); #1;
         check(m_valid == 0, "R3", "no output inside group", m_valid, 0);
      end
      s_bin = 3;
      @(posedge clk); #1;
      s_valid = 0;
      check(m_valid == 1, "R3", "valid after last bin", m_valid, 1);
      check(m_bin == 0 && m_re == 4 && m_im == 8, "R3", "first group re", longint'(m_re), 4);
      repeat (3) @(posedge clk);
   endtask

   initial begin
      #(8 * 150000);
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      run_block(0, 1, 0, -1, "R2");          // default bypass (R1, R2)
      set_cfg(2); run_block(2, 2, 0, -1, "R3");
      t_latency();
      set_cfg(6); run_block(6, 0, 1, -1, "R4");  // most negative x64
      set_cfg(1); run_block(1, 0, 2, -1, "R4");
      set_cfg(3); run_block(3, 3, 0, 0, "R6");   // mid-block write deferred
      run_block(0, 4, 0, -1, "R5");              // deferred write now active
      set_cfg(5); run_block(5, 5, 0, -1, "R5");
      set_cfg(7); run_block(5, 6, 0, -1, "R7");  // illegal setting ignored
      bp_en = 1; set_cfg(1); run_block(1, 7, 0, -1, "R8"); bp_en = 0;
      check(st_bad == 0 && st_chk > 0, "R8", "held output while stalled", st_bad, 0);
      gap_en = 1; set_cfg(2); run_block(2, 8, 0, -1, "R9"); gap_en = 0;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule